// File: doc/BRIEF.md
# Grøstl-256 Round Permutation Engine

This block computes one of the two 512-bit permutations used inside the Grøstl-256 compression function. Each permutation is applied to a 64-byte state held as an 8×8 byte grid. The two permutations, P and Q, use the same datapath. A mode bit selects between them, and only the round constants and the per-row rotation amounts depend on that bit. One full round is computed per clock cycle. A round consists of the constant injection, then byte substitution with the AES S-box, then the row rotation, then the column mixing over GF(2^8).

To launch a run, pulse `start` for one cycle while the engine is idle. On that cycle, present the state on `din` and the mode on `q_sel`. `busy` stays high while the rounds execute. `done` pulses for one cycle when the final state is available on `dout`. The result stays on `dout` until the next run is accepted. The surrounding compression logic feeds the two permutations and XORs their results with the chaining value. That logic, message padding and the output transform are not part of this block.

Top module: `gperm_core`

## Requirements
- R1: A synchronous active-high `rst` drives `busy` and `done` low and clears the state register, so `dout` reads all zeros after reset.
- R2: A `start` pulse seen while `busy` is low captures `din` and `q_sel`, and `busy` is high in the following cycle.
- R3: `done` is high for exactly one cycle. That cycle comes NUM_ROUNDS (default 10) cycles after the cycle in which `start` was accepted.
- R4: `busy` stays high for exactly NUM_ROUNDS cycles per run and is low whenever `done` is high.
- R5: A `start` that arrives while `busy` is high is ignored. It does not change the result, the mode or the completion time of the run in progress.
- R6: With `q_sel`=0 (P), round r XORs the byte in row 0, column j with ((j<<4) XOR r). Row i is then rotated left by i byte positions.
- R7: With `q_sel`=1 (Q), round r XORs every byte with 0xFF and XORs the byte in row 7, column j with ((j<<4) XOR r). Rows 0..7 are then rotated left by 1,3,5,7,0,2,4,6 positions respectively.
- R8: Byte k of `din` and `dout` occupies bits [8k+7:8k], and byte 8·c+r is the grid element at row r, column c.
- R9: Both modes use the same substitution and mixing. Substitution is the AES S-box (inverse modulo x^8+x^4+x^3+x+1 followed by the affine map with constant 0x63). Mixing multiplies each column by the circulant matrix whose first row is 2,2,3,4,5,3,5,7.
- R10: While the engine is idle and no `start` arrives, `dout` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, accepted only while idle |
| q_sel | input | 1 | Mode: 0 selects P, 1 selects Q |
| din | input | 512 | Initial state, column-major bytes |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse marking the final state |
| dout | output | 512 | Current state; final result once `done` has pulsed |

## Verification
The bench builds the engine with the default NUM_ROUNDS of 10, which is the real Grøstl-256 round count. Each result can therefore be compared bit for bit with the bench's own model of the permutation, in both modes. That round count also exercises the round index in the constant across values 0 to 9, as well as the exact ten-cycle `busy` window. Within that window the bench places spurious starts, a start held high, a start on the `done` cycle itself, and a reset in the middle of a run.

// File: rtl/gperm_pkg.sv
package gperm_pkg;

   localparam int GP_DIM   = 8;
   localparam int GP_BYTES = GP_DIM * GP_DIM;
   localparam int GP_W     = GP_BYTES * 8;

   typedef logic [7:0] gbyte_t;
   typedef gbyte_t [GP_DIM-1:0] gcol_t;
   typedef gbyte_t [GP_DIM-1:0][GP_DIM-1:0] grid_t;   // [row][col]

   function automatic gbyte_t gf_dbl(input gbyte_t a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
   endfunction

   // multiply by a small constant 0..7
   function automatic gbyte_t gf_kmul(input gbyte_t a, input logic [2:0] k);
      gbyte_t a2, a4;
      a2 = gf_dbl(a);
      a4 = gf_dbl(a2);
      return (k[0] ? a : 8'h00) ^ (k[1] ? a2 : 8'h00) ^ (k[2] ? a4 : 8'h00);
   endfunction

   function automatic gbyte_t gf_mul(input gbyte_t a, input gbyte_t b);
      gbyte_t acc, sh;
      acc = 8'h00;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = gf_dbl(sh);
      end
      return acc;
   endfunction

   // S-box: x^254 as the field inverse, then the affine map
   function automatic gbyte_t gf_sbox(input gbyte_t x);
      gbyte_t p, y, s;
      p = x;
      y = 8'h01;
      for (int i = 0; i < 7; i++) begin
         p = gf_mul(p, p);
         y = gf_mul(y, p);
      end
      for (int i = 0; i < 8; i++)
         s[i] = y[i] ^ y[(i+4)%8] ^ y[(i+5)%8] ^ y[(i+6)%8] ^ y[(i+7)%8];
      return s ^ 8'h63;
   endfunction

   // first row of the circulant mixing matrix
   function automatic logic [2:0] mix_coef(input int idx);
      case (idx)
         0, 1:    return 3'd2;
         2, 5:    return 3'd3;
         3:       return 3'd4;
         4, 6:    return 3'd5;
         default: return 3'd7;
      endcase
   endfunction

endpackage

// File: rtl/gperm_mixcol.sv
module gperm_mixcol
   import gperm_pkg::*;
(
   input  gcol_t col_i,
   output gcol_t col_o
);

   for (genvar i = 0; i < GP_DIM; i++) begin : g_out
      always_comb begin
         col_o[i] = 8'h00;
         for (int j = 0; j < GP_DIM; j++)
            col_o[i] = col_o[i] ^ gf_kmul(col_i[j], mix_coef((j - i + GP_DIM) % GP_DIM));
      end
   end

endmodule

// File: rtl/gperm_round.sv
module gperm_round
   import gperm_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  grid_t            st_i,
   input  logic             q_mode,
   input  logic [CNT_W-1:0] rnd,
   output grid_t            st_o
);

   grid_t subd, shifted;

   initial begin
      if (CNT_W < 1 || CNT_W > 4)
         $error("gperm_round: CNT_W must lie in 1..4");
   end

   for (genvar r = 0; r < GP_DIM; r++) begin : g_row
      localparam int SH_P = r;
      localparam int SH_Q = (r < 4) ? (2*r + 1) : (2*(r - 4));
      for (genvar c = 0; c < GP_DIM; c++) begin : g_col
         localparam logic [7:0] COL_K = 8'(c << 4);
         gbyte_t inj;
         always_comb begin
            inj = st_i[r][c];
            if (q_mode) begin
               inj = inj ^ 8'hFF;
               if (r == GP_DIM-1) inj = inj ^ COL_K ^ 8'(rnd);
            end else if (r == 0) begin
               inj = inj ^ COL_K ^ 8'(rnd);
            end
            subd[r][c] = gf_sbox(inj);
         end
         assign shifted[r][c] = q_mode ? subd[r][(c + SH_Q) % GP_DIM]
                                       : subd[r][(c + SH_P) % GP_DIM];
      end
   end

   for (genvar c = 0; c < GP_DIM; c++) begin : g_mix
      gcol_t col_in, col_out;
      for (genvar r = 0; r < GP_DIM; r++) begin : g_pick
         assign col_in[r]   = shifted[r][c];
         assign st_o[r][c]  = col_out[r];
      end
      gperm_mixcol u_mix (.col_i(col_in), .col_o(col_out));
   end

endmodule

// File: rtl/gperm_core.sv
module gperm_core
   import gperm_pkg::*;
#(
   parameter int NUM_ROUNDS = 10
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic            q_sel,
   input  logic [GP_W-1:0] din,
   output logic            busy,
   output logic            done,
   output logic [GP_W-1:0] dout
);

   localparam int               CNT_W = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1;
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(NUM_ROUNDS - 1);

   initial begin
      if (NUM_ROUNDS < 1 || NUM_ROUNDS > 16)
         $error("gperm_core: NUM_ROUNDS must lie in 1..16");
   end

   grid_t            st_q, st_in, st_nx;
   logic             mode_q;
   logic [CNT_W-1:0] rnd_q;

   // column-major byte placement (R8)
   for (genvar c = 0; c < GP_DIM; c++) begin : g_c
      for (genvar r = 0; r < GP_DIM; r++) begin : g_r
         assign st_in[r][c]                 = din[8*(GP_DIM*c + r) +: 8];
         assign dout[8*(GP_DIM*c + r) +: 8] = st_q[r][c];
      end
   end

   gperm_round #(.CNT_W(CNT_W)) u_round (
      .st_i  (st_q),
      .q_mode(mode_q),
      .rnd   (rnd_q),
      .st_o  (st_nx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= '0;
         mode_q <= 1'b0;
         rnd_q  <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            st_q  <= st_nx;
            rnd_q <= rnd_q + 1'b1;
            if (rnd_q == LAST) begin
               busy  <= 1'b0;
               done  <= 1'b1;
               rnd_q <= '0;
            end
         end else if (start) begin
            st_q   <= st_in;
            mode_q <= q_sel;
            rnd_q  <= '0;
            busy   <= 1'b1;
         end
      end
   end

   assert_reset_R1: assert property (@(posedge clk) rst |=> (!busy && !done && dout == '0));
   assert_accept_R2: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
   assert_pulse_R3: assert property (@(posedge clk) disable iff (rst) done |=> !done);
   assert_round_bound_R3: assert property (@(posedge clk) disable iff (rst) busy |-> (rnd_q <= LAST));
   assert_exclusive_R4: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
   assert_ignore_R5: assert property (@(posedge clk) disable iff (rst)
      (busy && rnd_q != LAST) |=> (busy && $stable(mode_q)));
   assert_hold_R10: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> $stable(dout));

endmodule

// File: tb/sim_gperm_core.sv
`timescale 1ns/1ps
module sim_gperm_core;

   localparam int NR = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic         q_sel = 1'b0;
   logic [511:0] din = '0;
   logic         busy, done;
   logic [511:0] dout;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;   // 125 MHz

   gperm_core #(.NUM_ROUNDS(NR)) u0 (
      .clk(clk), .rst(rst), .start(start), .q_sel(q_sel),
      .din(din), .busy(busy), .done(done), .dout(dout)
   );

   // ---------------- field arithmetic via log/antilog tables ----------------
   int exp_t[256];
   int log_t[256];

   initial begin
      int x;
      x = 1;
      for (int i = 0; i < 255; i++) begin
         exp_t[i] = x;
         log_t[x] = i;
         x = x ^ (((x << 1) ^ ((x & 8'h80) != 0 ? 8'h1B : 0)) & 8'hFF);
      end
      log_t[0] = 0;
   end

   function automatic int fmul(input int a, input int b);
      if (a == 0 || b == 0) return 0;
      return exp_t[(log_t[a] + log_t[b]) % 255];
   endfunction

   function automatic int rotl8(input int v, input int n);
      return ((v << n) | (v >> (8 - n))) & 8'hFF;
   endfunction

   function automatic int fsbox(input int x);
      int b;
      b = (x == 0) ? 0 : exp_t[(255 - log_t[x]) % 255];
      return b ^ rotl8(b,1) ^ rotl8(b,2) ^ rotl8(b,3) ^ rotl8(b,4) ^ 8'h63;
   endfunction

   // reference permutation, written from R6, R7, R8, R9
   function automatic logic [511:0] ref_perm(input logic [511:0] x, input bit q);
      int s[8][8];
      int t[8][8];
      int circ[8] = '{2,2,3,4,5,3,5,7};
      int shp[8]  = '{0,1,2,3,4,5,6,7};
      int shq[8]  = '{1,3,5,7,0,2,4,6};
      logic [511:0] y;
      for (int c = 0; c < 8; c++)
         for (int r = 0; r < 8; r++)
            s[r][c] = int'(x[8*(8*c+r) +: 8]);
      for (int rd = 0; rd < NR; rd++) begin
         for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
               int v;
               v = s[r][c];
               if (q) v = v ^ 8'hFF;
               if ((q && r == 7) || (!q && r == 0)) v = v ^ ((c << 4) ^ rd);
               s[r][c] = fsbox(v);
            end
         for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
               int sh;
               sh = q ? shq[r] : shp[r];
               t[r][(c - sh + 8) % 8] = s[r][c];
            end
         for (int c = 0; c < 8; c++)
            for (int i = 0; i < 8; i++) begin
               int acc;
               acc = 0;
               for (int j = 0; j < 8; j++)
                  acc = acc ^ fmul(circ[(j - i + 8) % 8], t[j][c]);
               s[i][c] = acc;
            end
      end
      for (int c = 0; c < 8; c++)
         for (int r = 0; r < 8; r++)
            y[8*(8*c+r) +: 8] = 8'(s[r][c]);
      return y;
   endfunction

   // ---------------- cycle model ----------------
   bit           live = 0;
   bit           m_busy = 0, m_done = 0, m_q = 0;
   int           m_cnt = 0;
   logic [511:0] m_dout = '0, m_res = '0;

   always @(posedge clk) begin
      live = 1;
      if (rst) begin
         m_busy = 0; m_done = 0; m_cnt = 0; m_dout = '0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_cnt++;
            if (m_cnt == NR) begin
               m_busy = 0;
               m_done = 1;
               m_dout = m_res;
            end
         end else if (start) begin
            m_busy = 1;
            m_cnt  = 0;
            m_q    = q_sel;
            m_res  = ref_perm(din, q_sel);
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (live) begin
         check(busy === m_busy, "R2 R4 busy", 512'(busy), 512'(m_busy));
         check(done === m_done, "R3 done", 512'(done), 512'(m_done));
         if (!m_busy)
            check(dout === m_dout, m_q ? "R7 R8 R9 R10 dout" : "R6 R8 R9 R10 dout", dout, m_dout);
      end
   end

   task automatic launch(input logic [511:0] d, input bit q);
      @(negedge clk);
      start = 1'b1; din = d; q_sel = q;
      @(negedge clk);
      start = 1'b0; din = ~d;
   endtask

   task automatic wait_idle();
      while (m_busy) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [511:0] ramp(input int base);
      logic [511:0] v;
      for (int k = 0; k < 64; k++) v[8*k +: 8] = 8'(base + k);
      return v;
   endfunction

   initial begin : wdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      logic [511:0] rv;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(busy === 1'b0 && done === 1'b0, "R1 flags", {busy, done}, 512'd0);
      check(dout === '0, "R1 dout", dout, '0);
      rst = 1'b0;
      @(negedge clk);

      // R6 / R7 on fixed patterns
      launch('0, 1'b0);            wait_idle();
      launch('0, 1'b1);            wait_idle();
      launch({512{1'b1}}, 1'b0);   wait_idle();
      launch({512{1'b1}}, 1'b1);   wait_idle();
      launch(ramp(0), 1'b0);       wait_idle();
      launch(ramp(8'h80), 1'b1);   wait_idle();
      // R8: single nonzero byte at distinct positions
      for (int k = 0; k < 64; k += 9) begin
         rv = '0; rv[8*k +: 8] = 8'h01;
         launch(rv, k[0]);
         wait_idle();
      end

      // R5: spurious starts during a run with different data and mode
      launch(ramp(3), 1'b0);
      repeat (3) @(negedge clk);
      start = 1'b1; din = ramp(77); q_sel = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();

      // R5 / R3: start held high -> back-to-back runs, start on done cycle
      @(negedge clk);
      start = 1'b1; din = ramp(9); q_sel = 1'b1;
      repeat (2*NR + 4) @(negedge clk);
      start = 1'b0;
      wait_idle();

      // random patterns in both modes
      for (int n = 0; n < 16; n++) begin
         for (int k = 0; k < 16; k++) rv[32*k +: 32] = $urandom;
         launch(rv, n[0]);
         wait_idle();
      end

      // R1: reset in the middle of a run
      launch(ramp(5), 1'b1);
      repeat (4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(busy === 1'b0 && dout === '0, "R1 mid-run reset", dout, '0);
      rst = 1'b0;
      @(negedge clk);
      launch(ramp(6), 1'b0);
      wait_idle();

      // R10: idle hold with input toggling and no start
      din = ramp(200); q_sel = 1'b1;
      repeat (5) @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule